// File: doc/BRIEF.md
# Set/Clear Encoded Control Register Bank

This block is a bank of 16-bit control registers in which software never stores a value outright. Every write word carries two 8-bit masks. The upper byte asks for bits to be raised and the lower byte asks for bits to be dropped. Each of the eight state bits in the addressed register reacts only to its own pair of requests. Software can therefore change one flag without first reading the register, and a change made by hardware between a read and a write is never overwritten.

The bank holds a few global registers followed by a group of sixteen per-object registers, and all of them share the same write rule. Protocol logic next to the bank drives per-register set and clear vectors that act on the same clock edge as a bus write. Where the two sources collide on one bit, the hardware request decides the result. A read returns the full 16-bit word. The upper byte of that word is always zero.

Top module: `scr_bank`

## Requirements
- R1: Synchronous active-low reset clears every state bit of every register to 0.
- R2: On a write, a state bit n (n = 0..7) with write-data bit n+8 at 1 and bit n at 0 becomes 1 at the next clock edge.
- R3: On a write, a state bit n with write-data bit n at 1 and bit n+8 at 0 becomes 0 at the next clock edge.
- R4: On a write, a state bit whose two request bits are both 1 or both 0 keeps its value.
- R5: A register holding 0xD1 that receives the write word 0x0BD8 holds 0x03 afterwards.
- R6: While rd_en is 1 and the index is mapped, rd_data is {8'h00, state} of the indexed register in the same cycle. At all other times rd_data is 0, and its upper byte is never nonzero.
- R7: A write changes only the register selected by addr. Indices 0 to NUM_REGS-1 are mapped.
- R8: A write to an index of NUM_REGS or above changes no state, and a read of such an index returns 0.
- R9: A hw_set bit (register r, bit n sits at position r*8+n) forces that state bit to 1 at the next edge, and a hw_clr bit forces it to 0. If both are set for the same bit, the set wins.
- R10: When a bus write and a hardware request target the same bit in one cycle, the hardware request decides the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | IDX_W (5) | Register index for both reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Set mask in [15:8], clear mask in [7:0] |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read word, upper byte 0 |
| hw_set | input | NUM_REGS*8 | Hardware set requests, register r at bits r*8 +: 8 |
| hw_clr | input | NUM_REGS*8 | Hardware clear requests, same layout |

## Verification
The bound checker watches several rules on every cycle. It confirms that a hardware set or clear lands on the next edge, with set beating clear, and that an idle cycle or a write to an unmapped index leaves the whole state vector stable. It also confirms that the upper read byte stays zero and that reset empties the bank. Other behaviour can only be shown by the bench's scenarios, because it depends on which register is addressed and on the mask pattern. This covers the per-bit set/clear/hold decode, the 0xD1/0x0BD8 case, isolation between registers, unmapped reads, and bus-versus-hardware collisions. A long random run compares every result against a mask model kept in the bench.

// File: rtl/scr_pkg.sv
package scr_pkg;
    // Width of the state field held in each register
    localparam int SCR_STATE_W = 8;
    // Registers: global ones followed by the per-object group
    localparam int SCR_GLOBAL_REGS = 4;
    localparam int SCR_OBJECT_REGS = 16;
    localparam int SCR_NUM_REGS    = SCR_GLOBAL_REGS + SCR_OBJECT_REGS;

    // Meaning of a request pair seen by one state bit
    typedef enum logic [1:0] {
        REQ_HOLD  = 2'b00,
        REQ_DROP  = 2'b01,
        REQ_RAISE = 2'b10,
        REQ_BOTH  = 2'b11
    } req_pair_e;
endpackage

// File: rtl/scr_decode.sv
module scr_decode #(
    parameter int NUM_REGS = 20,
    parameter int IDX_W    = 5
) (
    input  logic [IDX_W-1:0]    addr,
    output logic [NUM_REGS-1:0] sel,
    output logic                hit
);
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == IDX_W'(i)) sel[i] = 1'b1;
        end
        hit = |sel;
    end
endmodule

// File: rtl/scr_cell.sv
module scr_cell
    import scr_pkg::*;
#(
    parameter int STATE_W = SCR_STATE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_sel,
    input  logic [STATE_W-1:0] set_m,
    input  logic [STATE_W-1:0] clr_m,
    input  logic [STATE_W-1:0] hw_set,
    input  logic [STATE_W-1:0] hw_clr,
    output logic [STATE_W-1:0] state
);
    logic [STATE_W-1:0] bus_next;
    logic [STATE_W-1:0] state_next;

    // Bus request decode, one bit at a time
    always_comb begin
        for (int b = 0; b < STATE_W; b++) begin
            unique case (req_pair_e'({set_m[b], clr_m[b]}))
                REQ_RAISE: bus_next[b] = wr_sel ? 1'b1 : state[b];
                REQ_DROP:  bus_next[b] = wr_sel ? 1'b0 : state[b];
                REQ_HOLD,
                REQ_BOTH:  bus_next[b] = state[b];
                default:   bus_next[b] = state[b];
            endcase
        end
    end

    // Hardware requests override the bus; set beats clear
    always_comb begin
        state_next = (bus_next & ~hw_clr) | hw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= '0;
        else        state <= state_next;
    end
endmodule

// File: rtl/scr_bank.sv
module scr_bank
    import scr_pkg::*;
#(
    parameter int NUM_REGS = SCR_NUM_REGS,
    parameter int STATE_W  = SCR_STATE_W,
    parameter int IDX_W    = 5,
    localparam int DATA_W  = 2 * STATE_W,
    localparam int FLAT_W  = NUM_REGS * STATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [FLAT_W-1:0] hw_set,
    input  logic [FLAT_W-1:0] hw_clr
);
    logic [NUM_REGS-1:0] sel;
    logic                hit;
    logic [FLAT_W-1:0]   state_flat;
    logic [STATE_W-1:0]  set_m;
    logic [STATE_W-1:0]  clr_m;
    logic [STATE_W-1:0]  rd_state;

    assign set_m = wr_data[DATA_W-1:STATE_W];
    assign clr_m = wr_data[STATE_W-1:0];

    scr_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
        .addr (addr),
        .sel  (sel),
        .hit  (hit)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        scr_cell #(.STATE_W(STATE_W)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_sel (wr_en & sel[r]),
            .set_m  (set_m),
            .clr_m  (clr_m),
            .hw_set (hw_set[r*STATE_W +: STATE_W]),
            .hw_clr (hw_clr[r*STATE_W +: STATE_W]),
            .state  (state_flat[r*STATE_W +: STATE_W])
        );
    end

    // One-hot read mux
    always_comb begin
        rd_state = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (sel[r]) rd_state = rd_state | state_flat[r*STATE_W +: STATE_W];
        end
        rd_data = (rd_en && hit) ? {{STATE_W{1'b0}}, rd_state} : '0;
    end
endmodule

// File: rtl/scr_bank_chk.sv
module scr_bank_chk #(
    parameter int NUM_REGS = 20,
    parameter int STATE_W  = 8,
    parameter int IDX_W    = 5,
    localparam int DATA_W  = 2 * STATE_W,
    localparam int FLAT_W  = NUM_REGS * STATE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [FLAT_W-1:0] hw_set,
    input logic [FLAT_W-1:0] hw_clr,
    input logic [FLAT_W-1:0] state_flat
);
    // R1: reset empties the bank
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> state_flat == '0);

    // R6: upper read byte always zero
    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:STATE_W] == '0);

    // R9: hardware set lands on the next edge
    assert_hw_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((state_flat & $past(hw_set)) == $past(hw_set)));

    // R9: hardware clear lands unless set asked too
    assert_hw_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((state_flat & $past(hw_clr & ~hw_set)) == '0));

    // R8: unmapped write with no hardware activity changes nothing
    assert_unmapped_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(addr) >= NUM_REGS) && hw_set == '0 && hw_clr == '0)
        |=> $stable(state_flat));

    // R4: no write and no hardware request holds every bit
    assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && hw_set == '0 && hw_clr == '0) |=> $stable(state_flat));
endmodule

bind scr_bank scr_bank_chk #(
    .NUM_REGS (NUM_REGS),
    .STATE_W  (STATE_W),
    .IDX_W    (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .rd_data    (rd_data),
    .hw_set     (hw_set),
    .hw_clr     (hw_clr),
    .state_flat (state_flat)
);

// File: tb/scr_bank_test.sv
module scr_bank_test;
    localparam int NR = 20;
    localparam int SW = 8;
    localparam int IW = 5;
    localparam int FW = NR * SW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [IW-1:0] addr;
    logic          wr_en;
    logic [15:0]   wr_data;
    logic          rd_en;
    logic [15:0]   rd_data;
    logic [FW-1:0] hw_set;
    logic [FW-1:0] hw_clr;

    logic [SW-1:0] model [NR];
    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    scr_bank uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .hw_set(hw_set), .hw_clr(hw_clr)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    // Reference: (cur & ~clear_only) | set_only, then hardware on top
    function automatic logic [SW-1:0] bus_upd(input logic [SW-1:0] cur, input logic [15:0] w);
        logic [SW-1:0] s = w[15:8];
        logic [SW-1:0] c = w[7:0];
        return (cur & ~(c & ~s)) | (s & ~c);
    endfunction

    function automatic void model_step(input logic we, input logic [IW-1:0] a, input logic [15:0] w,
                                       input logic [FW-1:0] hs, input logic [FW-1:0] hc);
        for (int r = 0; r < NR; r++) begin
            logic [SW-1:0] v = model[r];
            if (we && int'(a) == r) v = bus_upd(v, w);
            model[r] = (v & ~hc[r*SW +: SW]) | hs[r*SW +: SW];
        end
    endfunction

    // One clock of activity, driven at the falling edge
    task automatic cycle(input logic we, input logic [IW-1:0] a, input logic [15:0] w,
                         input logic [FW-1:0] hs, input logic [FW-1:0] hc);
        @(negedge clk);
        wr_en = we; addr = a; wr_data = w; hw_set = hs; hw_clr = hc;
        model_step(we, a, w, hs, hc);
        @(negedge clk);
        wr_en = 1'b0; hw_set = '0; hw_clr = '0; wr_data = '0;
    endtask

    task automatic read_chk(input string tag, input logic [IW-1:0] a, input logic [15:0] exp);
        addr = a; rd_en = 1'b1;
        #1;
        check(tag, rd_data, exp);
        rd_en = 1'b0;
        #1;
    endtask

    task automatic test_reset;
        for (int r = 0; r < NR; r++) read_chk("R1 reset state", IW'(r), 16'h0000);
        addr = 5'd0; rd_en = 1'b0; #1;
        check("R6 idle read is zero", rd_data, 16'h0000);
    endtask

    task automatic test_check_case;
        cycle(1'b1, 5'd2, 16'hD100, '0, '0);
        read_chk("R2 load 0xD1 via set mask", 5'd2, 16'h00D1);
        cycle(1'b1, 5'd2, 16'h0BD8, '0, '0);
        read_chk("R5 0xD1 with 0x0BD8", 5'd2, 16'h0003);
    endtask

    task automatic test_pairs;
        // reg 6 starts 0; bits 0..3 set, then pair patterns
        cycle(1'b1, 5'd6, 16'h0F00, '0, '0);
        read_chk("R2 set-only", 5'd6, 16'h000F);
        cycle(1'b1, 5'd6, 16'h0003, '0, '0);
        read_chk("R3 clear-only", 5'd6, 16'h000C);
        cycle(1'b1, 5'd6, 16'hF0F0, '0, '0);
        read_chk("R4 both requests hold", 5'd6, 16'h000C);
        cycle(1'b1, 5'd6, 16'h0000, '0, '0);
        read_chk("R4 no requests hold", 5'd6, 16'h000C);
    endtask

    task automatic test_isolation;
        cycle(1'b1, 5'd19, 16'hAA00, '0, '0);
        read_chk("R7 target written", 5'd19, 16'h00AA);
        read_chk("R7 neighbour untouched", 5'd18, {8'h00, model[18]});
        read_chk("R7 first object reg untouched", 5'd4, {8'h00, model[4]});
    endtask

    task automatic test_unmapped;
        cycle(1'b1, 5'd20, 16'hFF00, '0, '0);
        cycle(1'b1, 5'd31, 16'hFF00, '0, '0);
        for (int r = 0; r < NR; r++) read_chk("R8 unmapped write no effect", IW'(r), {8'h00, model[r]});
        read_chk("R8 unmapped read", 5'd25, 16'h0000);
    endtask

    task automatic test_hw;
        logic [FW-1:0] hs = '0;
        logic [FW-1:0] hc = '0;
        hs[9*SW + 5] = 1'b1;
        hc[9*SW + 5] = 1'b1;
        hs[9*SW + 1] = 1'b1;
        cycle(1'b0, 5'd0, 16'h0000, hs, hc);
        read_chk("R9 hw set, set beats clear", 5'd9, 16'h0022);
        hs = '0; hc = '0;
        hc[9*SW + 1] = 1'b1;
        cycle(1'b0, 5'd0, 16'h0000, hs, hc);
        read_chk("R9 hw clear", 5'd9, 16'h0020);
    endtask

    task automatic test_conflict;
        logic [FW-1:0] hs = '0;
        logic [FW-1:0] hc = '0;
        cycle(1'b1, 5'd3, 16'h0200, '0, '0);   // reg 3 = 0x02
        hc[3*SW + 0] = 1'b1;                   // bus sets bit0, hw clears it
        hs[3*SW + 1] = 1'b1;                   // bus clears bit1, hw sets it
        cycle(1'b1, 5'd3, 16'h0102, hs, hc);
        read_chk("R10 hardware wins over bus", 5'd3, 16'h0002);
    endtask

    task automatic test_random;
        for (int i = 0; i < 600; i++) begin
            logic [IW-1:0] a = IW'($urandom_range(0, 31));
            logic [15:0]   w = 16'($urandom);
            logic [FW-1:0] hs = '0;
            logic [FW-1:0] hc = '0;
            for (int r = 0; r < NR; r++) begin
                hs[r*SW +: SW] = SW'($urandom & $urandom & $urandom);
                hc[r*SW +: SW] = SW'($urandom & $urandom & $urandom);
            end
            cycle(1'b1, a, w, hs, hc);
            if (int'(a) < NR) read_chk("R2/R3/R4 random vs model", a, {8'h00, model[int'(a)]});
            else              read_chk("R8 random unmapped read", a, 16'h0000);
            begin
                int o = $urandom_range(0, NR - 1);
                read_chk("R7/R9 random other reg", IW'(o), {8'h00, model[o]});
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
        hw_set = '0; hw_clr = '0;
        for (int r = 0; r < NR; r++) model[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_check_case();
        test_pairs();
        test_isolation();
        test_unmapped();
        test_hw();
        test_conflict();
        test_random();
        // R1: reset mid-run clears everything again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int r = 0; r < NR; r++) model[r] = '0;
        for (int r = 0; r < NR; r++) read_chk("R1 reset after activity", IW'(r), 16'h0000);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule